// File: doc/BRIEF.md
# S-100 Bus Slave Byte Port

This block is a bus slave that gives an S-100 system one 8-bit I/O port at a fixed 16-bit address, 0068H by default. It samples the bus address, the output and input status bits, the active-low write strobe and the data-in strobe through a two-stage synchroniser into its own clock domain. An output cycle to its address stores the CPU's data-out byte in a register that drives eight indicator LEDs directly. An input cycle to its address places a byte on the data-in path toward the bus. That byte is either a 4-bit switch value repeated in both nibbles or the last byte written, depending on a mode pin.

The block also produces the active-low enables of the bus-side transceivers. The listening transceivers (address, status, control and data-out) are enabled only while the direction pin selects slave operation. The transceiver that drives data onto the bus is enabled only inside a decoded input cycle to this port. When the direction pin selects master operation, every enable stays inactive and the port neither captures nor answers.

Top module: `s100_io_port`

## Requirements
- R1: The port answers only when all 16 address bits equal PORT_ADDR (0068H). Any other address, including 0168H or 6868H whose low byte matches, causes neither a capture nor a read response.
- R2: A write is captured when the synchronised write strobe falls while the synchronised output status is high, the address matches and dir is 0. The captured data-out byte then appears on `led[7:0]` within four clock cycles of the strobe falling at the pins.
- R3: Each low pulse of the write strobe captures at most once. Data-out changes while the strobe stays low leave `led` unchanged.
- R4: With mode=0, a read returns the switch value in both nibbles: `din_bus = {sw, sw}` (sw=0011 gives 00110011).
- R5: With mode=1, a read returns the byte most recently captured by a write, which is 00H after reset.
- R6: `din_oe_n` is low only while the synchronised input status, data-in strobe and address match are all true and dir is 0. `din_bus` is 00H whenever `din_oe_n` is high.
- R7: With dir=1 (master), `din_oe_n` and `listen_oe_n` are both high, and write cycles to the port leave `led` unchanged. With dir=0, `listen_oe_n` is low.
- R8: While rst_n is low, `led` is 00H, `din_oe_n` is high and `din_bus` is 00H.
- R9: A write strobe with the output status low, or one given during an input cycle without output status, leaves `led` unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock |
| rst_n | input | 1 | Active-low bus reset |
| addr | input | 16 | Bus address lines |
| s_out | input | 1 | Output-cycle status bit |
| s_inp | input | 1 | Input-cycle status bit |
| wr_n | input | 1 | Active-low write strobe |
| dbin | input | 1 | Data-in strobe |
| dout_bus | input | 8 | CPU data-out bus |
| sw | input | 4 | Switch value |
| mode | input | 1 | 0 switch read, 1 loopback read |
| dir | input | 1 | 0 slave, 1 master |
| led | output | 8 | Stored byte to the indicator LEDs |
| din_bus | output | 8 | Byte driven toward the bus data-in lines |
| din_oe_n | output | 1 | Active-low enable of the data-in driver |
| listen_oe_n | output | 1 | Active-low enable of the inbound transceivers |

## Verification
The hardest case to reach is a write strobe that stays low while the data-out bus keeps changing. A design that captures on level rather than on the strobe's falling edge would follow the new data. The bench holds the strobe low, changes the data, waits several synchroniser delays and confirms that the LEDs still show the first byte. Random addresses are biased so that near-misses sharing the low byte with the port address come up often. Status, mode and direction are drawn at random so that writes without output status and master-mode cycles occur alongside valid ones.

// File: rtl/s100_io_port.sv
module s100_io_port #(
  parameter int          ADDR_W    = 16,
  parameter int          DATA_W    = 8,
  parameter int          SW_W      = 4,
  parameter logic [15:0] PORT_ADDR = 16'h0068
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              s_out,
  input  logic              s_inp,
  input  logic              wr_n,
  input  logic              dbin,
  input  logic [DATA_W-1:0] dout_bus,
  input  logic [SW_W-1:0]   sw,
  input  logic              mode,
  input  logic              dir,
  output logic [DATA_W-1:0] led,
  output logic [DATA_W-1:0] din_bus,
  output logic              din_oe_n,
  output logic              listen_oe_n
);

  localparam int SYNC_W = ADDR_W + DATA_W + 4;
  localparam logic [SYNC_W-1:0] SYNC_IDLE = {{(ADDR_W + DATA_W + 2){1'b0}}, 1'b1, 1'b0};

  logic [SYNC_W-1:0] meta_q, sync_q;
  logic [ADDR_W-1:0] addr_s;
  logic [DATA_W-1:0] dout_s;
  logic              out_s, inp_s, wr_n_s, dbin_s, wr_n_q;
  logic [DATA_W-1:0] port_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= SYNC_IDLE;
      sync_q <= SYNC_IDLE;
      wr_n_q <= 1'b1;
    end else begin
      meta_q <= {addr, dout_bus, s_out, s_inp, wr_n, dbin};
      sync_q <= meta_q;
      wr_n_q <= wr_n_s;
    end
  end

  assign {addr_s, dout_s, out_s, inp_s, wr_n_s, dbin_s} = sync_q;

  logic hit, wr_fall, wr_take, rd_hit;
  assign hit     = (addr_s == PORT_ADDR[ADDR_W-1:0]) && !dir;
  assign wr_fall = wr_n_q && !wr_n_s;
  assign wr_take = wr_fall && out_s && hit;
  assign rd_hit  = inp_s && dbin_s && hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       port_q <= '0;
    else if (wr_take) port_q <= dout_s;
  end

  assign led         = port_q;
  assign listen_oe_n = dir;
  assign din_oe_n    = !rd_hit;
  assign din_bus     = !rd_hit ? '0 : (mode ? port_q : {(DATA_W / SW_W){sw}});

  a_r3_single_capture: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led) |-> $past(wr_n_q && !wr_n_s && out_s));

  a_r6_read_window: assert property (@(posedge clk) disable iff (!rst_n)
    !din_oe_n |-> (inp_s && dbin_s && addr_s == PORT_ADDR[ADDR_W-1:0] && !dir));

  a_r7_master_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    dir |-> (din_oe_n && listen_oe_n));

  a_r4_switch_byte: assert property (@(posedge clk) disable iff (!rst_n)
    (!din_oe_n && !mode) |-> (din_bus[DATA_W-1:DATA_W-SW_W] == din_bus[SW_W-1:0]));

  a_r6_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
    din_oe_n |-> (din_bus == '0));

  a_r1_full_match: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(led) |-> ($past(addr_s) == PORT_ADDR[ADDR_W-1:0]));

endmodule

// File: tb/s100_io_port_test.sv
module s100_io_port_test;
  localparam int CLK_NS = 10;
  localparam logic [15:0] PA = 16'h0068;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [15:0] addr = '0;
  logic s_out = 1'b0, s_inp = 1'b0, wr_n = 1'b1, dbin = 1'b0;
  logic [7:0] dout_bus = '0;
  logic [3:0] sw = '0;
  logic mode = 1'b0, dir = 1'b0;
  logic [7:0] led, din_bus;
  logic din_oe_n, listen_oe_n;

  int checks = 0, errors = 0;
  logic [7:0] exp_led = '0;
  bit done = 0;

  always #(CLK_NS/2) clk = ~clk;

  s100_io_port uut (
    .clk(clk), .rst_n(rst_n), .addr(addr), .s_out(s_out), .s_inp(s_inp),
    .wr_n(wr_n), .dbin(dbin), .dout_bus(dout_bus), .sw(sw), .mode(mode),
    .dir(dir), .led(led), .din_bus(din_bus), .din_oe_n(din_oe_n),
    .listen_oe_n(listen_oe_n));

  function automatic logic [7:0] read_byte(input logic m, input logic [3:0] s, input logic [7:0] stored);
    return m ? stored : {s, s};
  endfunction

  function automatic bit is_hit(input logic [15:0] a, input logic d);
    return (a == PA) && !d;
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic bus_write(input logic [15:0] a, input logic [7:0] d, input logic so, input logic hold_change);
    addr = a; dout_bus = d; s_out = so;
    cyc(2);
    wr_n = 1'b0;
    cyc(4);
    if (so && is_hit(a, dir)) exp_led = d;
    check(so ? "R2/R1/R7 write" : "R9 no status write", {24'b0, led}, {24'b0, exp_led});
    if (hold_change) begin
      dout_bus = ~d;
      cyc(4);
      check("R3 strobe held low", {24'b0, led}, {24'b0, exp_led});
    end
    wr_n = 1'b1;
    cyc(3);
    s_out = 1'b0;
    cyc(2);
  endtask

  task automatic bus_read(input logic [15:0] a);
    bit h;
    h = is_hit(a, dir);
    addr = a; s_inp = 1'b1; dbin = 1'b1;
    cyc(4);
    check("R6 read enable", {31'b0, din_oe_n}, {31'b0, !h});
    check(mode ? "R5 loopback read" : "R4 switch read", {24'b0, din_bus},
          {24'b0, h ? read_byte(mode, sw, exp_led) : 8'h00});
    check("R7 listen enable", {31'b0, listen_oe_n}, {31'b0, dir});
    s_inp = 1'b0; dbin = 1'b0;
    cyc(4);
    check("R6 idle after read", {23'b0, din_oe_n, din_bus}, {23'b0, 1'b1, 8'h00});
  endtask

  initial begin
    void'($urandom(32'd1234));
    cyc(3);
    check("R8 reset led", {24'b0, led}, 32'h0);
    check("R8 reset oe", {23'b0, din_oe_n, din_bus}, {23'b0, 1'b1, 8'h00});
    rst_n = 1'b1;
    cyc(2);
    mode = 1'b1;
    bus_read(PA);
    sw = 4'b0011; mode = 1'b0;
    bus_read(PA);
    check("R4 example 0011", {24'b0, din_bus}, 32'h0);
    bus_write(PA, 8'h33, 1'b1, 1'b1);
    bus_write(16'h0168, 8'h55, 1'b1, 1'b0);
    bus_write(16'h6868, 8'h66, 1'b1, 1'b0);
    bus_write(PA, 8'h77, 1'b0, 1'b0);
    mode = 1'b1;
    bus_read(PA);
    bus_read(16'h0168);
    dir = 1'b1;
    bus_write(PA, 8'hA5, 1'b1, 1'b0);
    bus_read(PA);
    dir = 1'b0;
    s_inp = 1'b1;
    bus_write(PA, 8'h99, 1'b0, 1'b0);
    s_inp = 1'b0;
    for (int i = 0; i < 300; i++) begin
      logic [15:0] a;
      int sel;
      sel = $urandom_range(0, 3);
      a = (sel < 2) ? PA : (sel == 2) ? {$urandom_range(1, 255), 8'h68} : 16'($urandom);
      sw = 4'($urandom);
      mode = 1'($urandom);
      dir = ($urandom_range(0, 7) == 0);
      if ($urandom_range(0, 1) == 1) bus_write(a, 8'($urandom), ($urandom_range(0, 4) != 0), ($urandom_range(0, 5) == 0));
      else bus_read(a);
    end
    rst_n = 1'b0;
    cyc(2);
    exp_led = '0;
    check("R8 reset again", {24'b0, led}, 32'h0);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule